// File: doc/BRIEF.md
# UART Line Activity Pin Driver

This block turns the activity strobes of one UART channel into two pin levels. Pin 0 shows transmit activity. It stays high while nothing is sent and blinks at a slow fixed rate while characters or a line break go out. Pin 1 has two uses. It can show receive activity in the same way. It can also act as the driver-enable for an RS-485 transceiver, with selectable polarity.

The blink timebase comes from the system clock. A half period is `HALF_CYCLES` clocks, and the default gives about 7.5 Hz from a 50 MHz clock. Activity is stretched, so every blink that starts runs through a full low-then-high period. Activity seen during a period starts one more period. The driver-enable is asserted while a character or a break is being sent. After the stop-bit strobe it stays asserted for `HOLD_BITS` baud ticks, so characters sent back to back keep it asserted with no gap.

The configuration inputs are treated as static. They are changed only while reset is asserted.

Top module: `line_activity_pins`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, pin0_out is 1. Pin1_out is 1 when the RS-485 function is off, and equals cfg_rs485_low when it is on.
- R2: With cfg_toggle_en=1, pin0_out goes low in the cycle after transmit activity is sampled while the pin is idle. It then stays low for HALF_CYCLES cycles and high for HALF_CYCLES cycles.
- R3: A break (brk_active=1) counts as transmit activity for pin0_out, in the same way as tx_busy.
- R4: A single-cycle activity strobe produces exactly one full blink period, after which the pin stays high. Activity sampled at any point in a period, including its last cycle, starts another period right after it with no idle cycle.
- R5: With cfg_rs485_en=0 and cfg_toggle_en=1, pin1_out blinks from rx_busy by the same rules as R2 and R4.
- R6: With cfg_rs485_en=1, the enable is active in every cycle that follows a cycle with tx_busy, brk_active or stop_done high.
- R7: After a stop_done strobe, the enable stays active until the HOLD_BITS-th baud_tick after the strobe. It goes inactive in the second cycle after that tick, unless new activity arrives.
- R8: A stop_done strobe that arrives while a hold is running restarts the full HOLD_BITS-tick hold. Characters separated by less than the hold therefore keep the enable continuously active.
- R9: The active level of the enable on pin1_out is 1 when cfg_rs485_low=0 and 0 when cfg_rs485_low=1.
- R10: With cfg_rs485_en=1, rx_busy has no effect on pin1_out.
- R11: With cfg_toggle_en=0 and cfg_rs485_en=0, both pins stay 1 whatever the activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| tx_busy | input | 1 | A character is being shifted out |
| brk_active | input | 1 | A line break is being sent |
| stop_done | input | 1 | One-cycle strobe at the end of a stop bit |
| rx_busy | input | 1 | A character is being received |
| cfg_toggle_en | input | 1 | Enables the activity blink function |
| cfg_rs485_en | input | 1 | Pin 1 carries the RS-485 driver-enable |
| cfg_rs485_low | input | 1 | Enable is active-low when set |
| pin0_out | output | 1 | Transmit activity indicator |
| pin1_out | output | 1 | Receive indicator or RS-485 enable |

## Verification
The hardest case to reach is a stop strobe that lands while an earlier hold is still counting baud ticks. The enable must not drop between such characters, and the hold must restart instead of running out. Random character streams with gaps shorter than the hold window reach this case again and again. A directed sequence of two strobes one tick apart confirms the restarted length. Directed cases also cover a strobe that lands in the last cycle of a blink period, where the next period must follow at once.

// File: rtl/line_activity_pkg.sv
package line_activity_pkg;
   typedef enum logic [1:0] {
      P1_STATIC   = 2'd0,
      P1_RX_BLINK = 2'd1,
      P1_DRV_EN   = 2'd2
   } pin1_fn_e;

   function automatic pin1_fn_e pick_pin1(input logic rs485_en, input logic toggle_en);
      if (rs485_en)       return P1_DRV_EN;
      else if (toggle_en) return P1_RX_BLINK;
      else                return P1_STATIC;
   endfunction
endpackage

// File: rtl/act_blinker.sv
module act_blinker #(
   parameter int unsigned HALF_CYCLES = 3_333_333
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   output logic blink_o
);
   localparam int unsigned CW = (HALF_CYCLES > 2) ? $clog2(HALF_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

   logic          running_q;
   logic          level_q;
   logic          pend_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         level_q   <= 1'b1;
         pend_q    <= 1'b0;
         cnt_q     <= '0;
      end else if (!running_q) begin
         if (act_i) begin
            running_q <= 1'b1;
            level_q   <= 1'b0;
            pend_q    <= 1'b0;
            cnt_q     <= '0;
         end
      end else begin
         if (act_i) pend_q <= 1'b1;
         if (cnt_q == LAST) begin
            cnt_q <= '0;
            if (!level_q) begin
               level_q <= 1'b1;
            end else if (pend_q || act_i) begin
               level_q <= 1'b0;
               pend_q  <= 1'b0;
            end else begin
               running_q <= 1'b0;
               pend_q    <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign blink_o = level_q;
endmodule

// File: rtl/drv_en_timer.sv
module drv_en_timer #(
   parameter int unsigned HOLD_BITS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_busy_i,
   input  logic brk_i,
   input  logic stop_i,
   input  logic baud_tick_i,
   output logic de_o
);
   localparam int unsigned HW = $clog2(HOLD_BITS + 1);

   logic          hold_q;
   logic [HW-1:0] left_q;
   logic          de_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         left_q <= '0;
         de_q   <= 1'b0;
      end else begin
         de_q <= tx_busy_i | brk_i | stop_i | hold_q;
         if (stop_i) begin
            hold_q <= 1'b1;
            left_q <= HW'(HOLD_BITS);
         end else if (hold_q && baud_tick_i) begin
            left_q <= left_q - 1'b1;
            if (left_q == HW'(1)) hold_q <= 1'b0;
         end
      end
   end

   assign de_o = de_q;
endmodule

// File: rtl/line_activity_pins.sv
module line_activity_pins #(
   parameter int unsigned HALF_CYCLES = 3_333_333,
   parameter int unsigned HOLD_BITS   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic baud_tick,
   input  logic tx_busy,
   input  logic brk_active,
   input  logic stop_done,
   input  logic rx_busy,
   input  logic cfg_toggle_en,
   input  logic cfg_rs485_en,
   input  logic cfg_rs485_low,
   output logic pin0_out,
   output logic pin1_out
);
   import line_activity_pkg::*;

   localparam int unsigned NCH = 2;

   if (HALF_CYCLES < 2) begin : g_bad_half
      $error("HALF_CYCLES must be at least 2");
   end
   if (HOLD_BITS < 1) begin : g_bad_hold
      $error("HOLD_BITS must be at least 1");
   end

   logic [NCH-1:0] act_vec;
   logic [NCH-1:0] blink_vec;
   logic           de_lvl;
   pin1_fn_e       p1_fn;

   assign act_vec[0] = tx_busy | brk_active;
   assign act_vec[1] = rx_busy;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      act_blinker #(.HALF_CYCLES(HALF_CYCLES)) u_blink (
         .clk    (clk),
         .rst_n  (rst_n),
         .act_i  (act_vec[ch]),
         .blink_o(blink_vec[ch])
      );
   end

   drv_en_timer #(.HOLD_BITS(HOLD_BITS)) u_de (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_busy_i  (tx_busy),
      .brk_i      (brk_active),
      .stop_i     (stop_done),
      .baud_tick_i(baud_tick),
      .de_o       (de_lvl)
   );

   assign p1_fn = pick_pin1(cfg_rs485_en, cfg_toggle_en);

   always_comb begin
      pin0_out = cfg_toggle_en ? blink_vec[0] : 1'b1;
      unique case (p1_fn)
         P1_DRV_EN:   pin1_out = de_lvl ^ cfg_rs485_low;
         P1_RX_BLINK: pin1_out = blink_vec[1];
         default:     pin1_out = 1'b1;
      endcase
   end
endmodule

// File: rtl/line_activity_pins_chk.sv
module line_activity_pins_chk #(
   parameter int unsigned HALF_CYCLES = 3_333_333
) (
   input logic clk,
   input logic rst_n,
   input logic tx_busy,
   input logic brk_active,
   input logic stop_done,
   input logic cfg_toggle_en,
   input logic cfg_rs485_en,
   input logic cfg_rs485_low,
   input logic pin0_out,
   input logic pin1_out
);
   int unsigned low_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         low_run_q <= 0;
      else if (!pin0_out && cfg_toggle_en) low_run_q <= low_run_q + 1;
      else                                low_run_q <= 0;
   end

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> pin0_out);

   assert_low_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_toggle_en && $past(rst_n) && $rose(pin0_out)) |-> (low_run_q == HALF_CYCLES));

   assert_de_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && cfg_rs485_en && ($past(tx_busy) || $past(brk_active) || $past(stop_done)))
         |-> (pin1_out == !cfg_rs485_low));

   assert_static_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_toggle_en && !cfg_rs485_en) |-> (pin0_out && pin1_out));
endmodule

bind line_activity_pins line_activity_pins_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_busy      (tx_busy),
   .brk_active   (brk_active),
   .stop_done    (stop_done),
   .cfg_toggle_en(cfg_toggle_en),
   .cfg_rs485_en (cfg_rs485_en),
   .cfg_rs485_low(cfg_rs485_low),
   .pin0_out     (pin0_out),
   .pin1_out     (pin1_out)
);

// File: tb/line_activity_pins_test.sv
module line_activity_pins_test;
   localparam int PERIOD = 10;
   localparam int H      = 6;
   localparam int HOLD   = 2;
   localparam int TICK_DIV = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 0, tx_busy = 0, brk_active = 0, stop_done = 0, rx_busy = 0;
   logic cfg_toggle_en = 0, cfg_rs485_en = 0, cfg_rs485_low = 0;
   logic pin0_out, pin1_out;

   int tests = 0, fails = 0;
   bit chk_on = 0, done = 0;
   string tag0 = "R2", tag1 = "R5";
   int tick_cnt = 0;
   int char_left = 0, gap_left = 0, brk_left = 0, rx_left = 0;

   bit on_m[2]; bit seen_m[2]; int ph_m[2];
   int hold_m; bit de_m; bit m_pin0, m_pin1;

   line_activity_pins #(.HALF_CYCLES(H), .HOLD_BITS(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_busy(tx_busy),
      .brk_active(brk_active), .stop_done(stop_done), .rx_busy(rx_busy),
      .cfg_toggle_en(cfg_toggle_en), .cfg_rs485_en(cfg_rs485_en),
      .cfg_rs485_low(cfg_rs485_low), .pin0_out(pin0_out), .pin1_out(pin1_out));

   always #(PERIOD/2) clk = ~clk;

   function automatic bit blink_lvl(bit on, int ph);
      return (!on || ph >= H);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin on_m[c] = 0; seen_m[c] = 0; ph_m[c] = 0; end
         hold_m = 0; de_m = 0;
      end else begin
         for (int c = 0; c < 2; c++) begin
            bit a;
            a = (c == 0) ? (tx_busy | brk_active) : rx_busy;
            if (!on_m[c]) begin
               if (a) begin on_m[c] = 1; ph_m[c] = 0; seen_m[c] = 0; end
            end else begin
               if (a) seen_m[c] = 1;
               ph_m[c]++;
               if (ph_m[c] == 2*H) begin
                  if (seen_m[c]) begin ph_m[c] = 0; seen_m[c] = 0; end
                  else on_m[c] = 0;
               end
            end
         end
         de_m = tx_busy | brk_active | stop_done | (hold_m > 0);
         if (stop_done) hold_m = HOLD;
         else if (baud_tick && hold_m > 0) hold_m--;
      end
      m_pin0 = cfg_toggle_en ? blink_lvl(on_m[0], ph_m[0]) : 1'b1;
      m_pin1 = cfg_rs485_en ? (de_m ^ cfg_rs485_low)
             : (cfg_toggle_en ? blink_lvl(on_m[1], ph_m[1]) : 1'b1);
   end

   task automatic check(input bit got, input bit exp, input string tag);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && chk_on) begin
         check(pin0_out, m_pin0, tag0);
         check(pin1_out, m_pin1, tag1);
      end
   end

   task automatic step(input bit b, input bit s, input bit k, input bit r);
      @(posedge clk); #1;
      baud_tick = (tick_cnt == TICK_DIV-1);
      tick_cnt = (tick_cnt == TICK_DIV-1) ? 0 : tick_cnt + 1;
      tx_busy = b; stop_done = s; brk_active = k; rx_busy = r;
   endtask

   task automatic do_reset(input bit tg, input bit rs, input bit lo);
      chk_on = 0;
      @(posedge clk); #1;
      rst_n = 0; tx_busy = 0; stop_done = 0; brk_active = 0; rx_busy = 0; baud_tick = 0;
      cfg_toggle_en = tg; cfg_rs485_en = rs; cfg_rs485_low = lo;
      char_left = 0; gap_left = 0; brk_left = 0; rx_left = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check(pin0_out, 1'b1, "R1");
      check(pin1_out, rs ? lo : 1'b1, "R1");
      chk_on = 1;
   endtask

   task automatic run_random(input int n, input int gap_max, input bit use_brk, input bit use_rx);
      for (int i = 0; i < n; i++) begin
         bit b, s, k, r;
         s = 0;
         if (char_left == 0) begin
            if (gap_left > 0) gap_left--;
            else if ($urandom % 4 == 0) char_left = 8 + $urandom % 12;
         end
         if (char_left > 0) begin
            b = 1; char_left--;
            if (char_left == 0) begin s = 1; gap_left = $urandom % (gap_max + 1); end
         end else b = 0;
         if (use_brk && brk_left == 0 && char_left == 0 && $urandom % 150 == 0) brk_left = 4 + $urandom % 20;
         k = (brk_left > 0); if (brk_left > 0) brk_left--;
         if (use_rx) begin
            if (rx_left > 0) rx_left--;
            else if ($urandom % 40 == 0) rx_left = 1 + $urandom % 15;
         end
         r = (rx_left > 0);
         step(b, s, k, r);
      end
      step(0, 0, 0, 0);
      repeat (3*H + 5*HOLD*TICK_DIV) step(0, 0, 0, 0);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int lows;
      void'($urandom(32'd4242));

      do_reset(1, 0, 0);
      tag0 = "R4"; tag1 = "R5";
      step(1, 0, 0, 0);
      lows = 0;
      for (int i = 0; i < 3*H; i++) begin
         step(0, 0, 0, 0);
         @(negedge clk);
         if (!pin0_out) lows++;
      end
      check(lows == H, 1'b1, "R4");
      step(1, 0, 0, 0);
      repeat (2*H - 1) step(0, 0, 0, 0);
      step(1, 0, 0, 0);
      repeat (4*H) step(0, 0, 0, 0);

      tag0 = "R3";
      step(0, 0, 1, 0); step(0, 0, 1, 0);
      repeat (3*H) step(0, 0, 0, 0);

      tag0 = "R2"; tag1 = "R5";
      run_random(3000, 40, 1, 1);
      run_random(2000, 2, 1, 1);

      do_reset(1, 1, 0);
      tag0 = "R2"; tag1 = "R7";
      step(1, 1, 0, 0);
      repeat (HOLD*TICK_DIV + 4) step(0, 0, 0, 1);
      tag1 = "R8";
      step(1, 1, 0, 0);
      while (!baud_tick) step(0, 0, 0, 0);
      step(0, 1, 0, 0);
      repeat (HOLD*TICK_DIV + 4) step(0, 0, 0, 0);
      tag1 = "R10";
      repeat (20) step(0, 0, 0, 1);
      tag1 = "R6";
      run_random(3000, 12, 1, 1);
      tag1 = "R8";
      run_random(2000, 1, 0, 1);

      do_reset(1, 1, 1);
      tag1 = "R9";
      run_random(2500, 12, 1, 1);

      do_reset(0, 0, 0);
      tag0 = "R11"; tag1 = "R11";
      run_random(1500, 8, 1, 1);

      chk_on = 0;
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule